// File: doc/BRIEF.md
# Interrupt Line to Priority-Level Mapper

This block collects eight level-sensitive device interrupt lines and presents them to a processor as a 16-bit vector of priority-level lines. Every source is steered through a fixed table to one level; a level line is raised while any source steered to it is active. Two of the eight sources are steered to level zero, which means "no interrupt", so they are dropped before they reach the pending state.

A single byte-wide control register sits on a minimal bus: a write strobe, write data and a read data port that always shows the stored byte. Bit 0 of that register is a global enable: while it is clear, every level line is held low, but the pending state keeps following the inputs. When the bit is set again, the lines at once reflect whatever is pending. Bit 6 of the register cannot be set.

Inputs are sampled on the rising clock edge. The level vector is a register that is loaded on the same edge that samples an input change or accepts a register write, so a change on either side is visible one clock later and is held steady in between.

Top module: `lvl_mapper_top`

## Requirements
- R1: For every source steered to a non-zero level, its pending bit equals the value the source input had at the most recent rising clock edge.
- R2: The steering table is fixed: source 1 to level 1, source 2 to level 4, source 3 to level 6, source 4 to level 8, source 5 to level 10, source 7 to level 14; sources 0 and 6 go to level 0.
- R3: Sources 0 and 6 never become pending and have no effect on any output line, whatever their level.
- R4: With the enable set, output line L (bit L of `lvl_out`) is high exactly when at least one pending source is steered to level L; lines with no pending source are low.
- R5: A write (`reg_we` high at a rising edge) stores `reg_wdata` ANDed with 0xBF, so bit 6 of the register is always zero.
- R6: `reg_rdata` always shows the stored register byte unchanged, and the byte holds its value in every cycle without a write.
- R7: After reset the register reads 0x01, nothing is pending and all 16 output lines are low.
- R8: Register bit 0 is the enable: while it is 0 all output lines are low and pending bits keep tracking the inputs; setting it again makes the outputs show the current pending state in the same update.
- R9: The output vector changes only on the rising edge that samples an input change or accepts a register write, taking the value implied by the new inputs and register; before that edge it holds its previous value.
- R10: Output line 0 is never driven high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Level-sensitive device interrupt sources |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| lvl_out | output | 16 | Registered priority-level lines |

## Verification
The bench builds the block with its default parameters: eight sources, sixteen levels, the default steering table, write mask 0xBF, reset value 0x01 and the enable at bit 0. These values put every table entry, both discarded sources, the forced-clear bit 6 and the enable toggle within reach of directed stimulus, and they let the bench compare each output vector against a table it holds itself. With eight inputs it also drives all 256 input patterns with the enable set and checks the full vector for each.

// File: rtl/lvl_mapper_pkg.sv
// Package lvl_mapper_pkg
// Default geometry and constants shared by the level mapper modules.
// Assumes a level field width of four bits for the default table.
package lvl_mapper_pkg;

    localparam int DEF_SRC_N  = 8;
    localparam int DEF_LVL_N  = 16;
    localparam int DEF_REG_W  = 8;
    localparam int DEF_EN_BIT = 0;

    // Level per source, four bits each, source 0 in the low nibble.
    localparam logic [31:0] DEF_MAP   = 32'hE0A8_6410;
    localparam logic [7:0]  DEF_WMASK = 8'hBF;
    localparam logic [7:0]  DEF_RESET = 8'h01;

endpackage

// File: rtl/lvl_mapper_ctrl.sv
// Module lvl_mapper_ctrl
// Holds the control byte. A write stores the data through a fixed mask.
// Provides the current byte and the value it will hold after this edge,
// so the output stage can update on the same edge as the write.
// Assumes a synchronous active-low reset.
module lvl_mapper_ctrl #(
    parameter int               REG_W = 8,
    parameter logic [REG_W-1:0] WMASK = 8'hBF,
    parameter logic [REG_W-1:0] RSTV  = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] ctrl_d
);

    // Next register value: masked write data or the held byte.
    always_comb begin
        ctrl_d = we ? (wdata & WMASK) : ctrl_q;
    end

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= RSTV;
        else        ctrl_q <= ctrl_d;
    end

    // Masked-off bits never appear in the stored byte (R5).
    p_mask_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~WMASK) == '0);

    // A write lands masked in the following cycle (R5).
    p_write_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ctrl_q == ($past(wdata) & WMASK));

    // Without a write the byte holds (R6).
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $past(rst_n)) |=> $stable(ctrl_q));

endmodule

// File: rtl/lvl_mapper_pending.sv
// Module lvl_mapper_pending
// Samples the source lines into the pending byte. Sources steered to
// level zero are discarded here and never become pending.
// Assumes sources are already synchronous to clk.
module lvl_mapper_pending #(
    parameter int                     SRC_N = 8,
    parameter int                     LVL_W = 4,
    parameter logic [SRC_N*LVL_W-1:0] MAP   = 32'hE0A8_6410
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] irq_in,
    output logic [SRC_N-1:0] pend_q,
    output logic [SRC_N-1:0] pend_d
);

    logic [SRC_N-1:0] live_mask;

    // Per-source keep mask derived from the table: level zero is dropped.
    for (genvar i = 0; i < SRC_N; i++) begin : g_mask
        localparam logic [LVL_W-1:0] LV = MAP[i*LVL_W +: LVL_W];
        assign live_mask[i] = (LV != '0);
    end

    // Next pending value follows the live inputs.
    always_comb begin
        pend_d = irq_in & live_mask;
    end

    // Pending register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // Each live source's pending bit matches the last sampled input (R1).
    for (genvar i = 0; i < SRC_N; i++) begin : g_chk
        localparam logic [LVL_W-1:0] LVC = MAP[i*LVL_W +: LVL_W];
        if (LVC != '0) begin : g_live
            p_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> pend_q[i] == $past(irq_in[i]));
        end else begin : g_dead
            p_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> !pend_q[i]);
        end
    end

endmodule

// File: rtl/lvl_mapper_route.sv
// Module lvl_mapper_route
// Turns the next pending byte into the level vector through the fixed
// table, gates it with the enable and registers it. Level zero is never
// driven. Assumes the inputs given are the values after the coming edge.
module lvl_mapper_route #(
    parameter int                     SRC_N = 8,
    parameter int                     LVL_N = 16,
    parameter int                     LVL_W = 4,
    parameter logic [SRC_N*LVL_W-1:0] MAP   = 32'hE0A8_6410
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] pend_d,
    input  logic             en_d,
    output logic [LVL_N-1:0] lvl_q
);

    logic [LVL_N-1:0][SRC_N-1:0] hit;
    logic [LVL_N-1:0]            lvl_d;

    // Hit matrix: source i drives level l when steered there and pending.
    for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
        for (genvar i = 0; i < SRC_N; i++) begin : g_src
            localparam logic [LVL_W-1:0] LV = MAP[i*LVL_W +: LVL_W];
            if (l != 0 && int'(LV) == l) begin : g_on
                assign hit[l][i] = pend_d[i];
            end else begin : g_off
                assign hit[l][i] = 1'b0;
            end
        end
        assign lvl_d[l] = en_d & (|hit[l]);
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    // With nothing pending and enable present, the vector is clear next (R4).
    p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_d == '0) |=> lvl_q == '0);

endmodule

// File: rtl/lvl_mapper_top.sv
// Module lvl_mapper_top
// Eight-source interrupt steering block: pending capture, control byte
// and registered level vector. Bit EN_BIT of the control byte enables
// the outputs. Assumes synchronous inputs and a synchronous active-low reset.
module lvl_mapper_top
    import lvl_mapper_pkg::*;
#(
    parameter int                     SRC_N  = DEF_SRC_N,
    parameter int                     LVL_N  = DEF_LVL_N,
    parameter int                     REG_W  = DEF_REG_W,
    parameter int                     EN_BIT = DEF_EN_BIT,
    parameter int                     LVL_W  = $clog2(LVL_N),
    parameter logic [SRC_N*LVL_W-1:0] MAP    = DEF_MAP,
    parameter logic [REG_W-1:0]       WMASK  = DEF_WMASK,
    parameter logic [REG_W-1:0]       RSTV   = DEF_RESET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] irq_in,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [LVL_N-1:0] lvl_out
);

    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] ctrl_d;
    logic [SRC_N-1:0] pend_q;
    logic [SRC_N-1:0] pend_d;

    // Control byte storage.
    lvl_mapper_ctrl #(
        .REG_W (REG_W),
        .WMASK (WMASK),
        .RSTV  (RSTV)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .wdata  (reg_wdata),
        .ctrl_q (ctrl_q),
        .ctrl_d (ctrl_d)
    );

    // Pending capture.
    lvl_mapper_pending #(
        .SRC_N (SRC_N),
        .LVL_W (LVL_W),
        .MAP   (MAP)
    ) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .pend_q (pend_q),
        .pend_d (pend_d)
    );

    // Level steering and output register.
    lvl_mapper_route #(
        .SRC_N (SRC_N),
        .LVL_N (LVL_N),
        .LVL_W (LVL_W),
        .MAP   (MAP)
    ) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_d (pend_d),
        .en_d   (ctrl_d[EN_BIT]),
        .lvl_q  (lvl_out)
    );

    // Read port shows the stored byte.
    assign reg_rdata = ctrl_q;

    // Disabled register means quiet outputs (R8).
    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[EN_BIT] |-> lvl_out == '0);

    // Level zero line is never raised (R10).
    p_no_level0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_out[0]);

    // Outputs hold when neither the pending state nor the register moved (R9).
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(pend_q) && $stable(ctrl_q)) |-> $stable(lvl_out));

endmodule

// File: tb/test_lvl_mapper_top.sv
module test_lvl_mapper_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_in = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] lvl_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    lvl_mapper_top i_lvl_mapper_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lvl_out   (lvl_out)
    );

    // Expected level for one source, from the table in R2.
    function automatic int src_level(input int s);
        case (s)
            1: return 1;
            2: return 4;
            3: return 6;
            4: return 8;
            5: return 10;
            7: return 14;
            default: return 0;
        endcase
    endfunction

    // Expected output vector from inputs and register (R4, R8, R10).
    function automatic logic [15:0] model(input logic [7:0] src, input logic [7:0] ctl);
        logic [15:0] v = '0;
        if (ctl[0]) begin
            for (int s = 0; s < 8; s++) begin
                if (src[s] && src_level(s) != 0) v[src_level(s)] = 1'b1;
            end
        end
        return v;
    endfunction

    task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance one edge and sample one time unit later.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_we = 1'b1;
        reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        irq_in = 8'hFF;
        step(); step();
        rst_n = 1'b1;
        irq_in = '0;
        chk8("R7 reset register", reg_rdata, 8'h01);
        chk16("R7 reset outputs", lvl_out, 16'h0000);
        step();
        chk16("R7 nothing pending after reset", lvl_out, 16'h0000);
    endtask

    task automatic t_walk();
        for (int s = 0; s < 8; s++) begin
            irq_in = 8'(1 << s);
            step();
            chk16("R2 single source steering", lvl_out, model(irq_in, 8'h01));
        end
        irq_in = '0;
        step();
        chk16("R1 deassert clears pending", lvl_out, 16'h0000);
    endtask

    task automatic t_all_patterns();
        for (int p = 0; p < 256; p++) begin
            irq_in = 8'(p);
            step();
            chk16("R4 pattern", lvl_out, model(8'(p), 8'h01));
        end
        irq_in = '0;
        step();
    endtask

    task automatic t_ignored();
        irq_in = 8'h41;
        step();
        chk16("R3 sources 0 and 6 ignored", lvl_out, 16'h0000);
        irq_in = 8'h43;
        step();
        chk16("R3 ignored alongside live source", lvl_out, 16'h0002);
        irq_in = 8'h02;
        step();
        chk16("R3 dropping ignored sources no change", lvl_out, 16'h0002);
        irq_in = '0;
        step();
    endtask

    task automatic t_write_mask();
        wr(8'hFF);
        chk8("R5 bit 6 forced clear", reg_rdata, 8'hBF);
        wr(8'h41);
        chk8("R5 write masked", reg_rdata, 8'h01);
        wr(8'h5A);
        chk8("R6 readback", reg_rdata, 8'h1A);
        step(); step();
        chk8("R6 byte holds without write", reg_rdata, 8'h1A);
        wr(8'h01);
    endtask

    task automatic t_enable();
        irq_in = 8'hA4;
        step();
        chk16("R4 multi source", lvl_out, model(8'hA4, 8'h01));
        wr(8'h00);
        chk16("R8 disabled outputs low", lvl_out, 16'h0000);
        irq_in = 8'h18;
        step();
        chk16("R8 disabled still low", lvl_out, 16'h0000);
        wr(8'h01);
        chk16("R8 re-enable shows tracked pending", lvl_out, model(8'h18, 8'h01));
        irq_in = '0;
        step();
    endtask

    task automatic t_timing();
        irq_in = 8'h80;
        #1;
        chk16("R9 held before edge", lvl_out, 16'h0000);
        step();
        chk16("R9 updated at edge", lvl_out, 16'h4000);
        step(); step();
        chk16("R9 held steady", lvl_out, 16'h4000);
        reg_we = 1'b1;
        reg_wdata = 8'h00;
        #1;
        chk16("R9 write not yet visible", lvl_out, 16'h4000);
        step();
        reg_we = 1'b0;
        chk16("R9 write visible after edge", lvl_out, 16'h0000);
        wr(8'h01);
        chk16("R10 line 0 low", {15'h0, lvl_out[0]}, 16'h0000);
        irq_in = '0;
        step();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset();
        t_walk();
        t_ignored();
        t_all_patterns();
        t_write_mask();
        t_enable();
        t_timing();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule